// File: doc/BRIEF.md
# Fill-Threshold Offset Loader

This block sets the two threshold offsets that a FIFO's fill-level flag logic compares against. One offset sets the low-water mark and the other sets the high-water mark. It runs on the write-side clock. While reset is held low, it decodes two select pins into one of four load modes. When reset is released, that mode is frozen. Two modes load a fixed preset into both offsets. One mode takes the offsets from the first two accepted port writes. One mode shifts them in one bit at a time through the select pins themselves.

The block also drives the write-ready output. In the preset and parallel modes, write-ready rises a fixed two clocks after reset is released. In the serial mode, it stays low until the bit stream is complete. The block also tells the memory-side logic which write strobes may store a word. Strobes used for programming never reach the memory. Strobes that arrive while write-ready is low are dropped.

Top module: `fill_offset_loader`

## Requirements
- R1: The select pin pair {`sel_sen`, `sel_sd`} sampled on the last clock while `rst_n` is low picks the mode: 2'b11 serial, 2'b10 large preset, 2'b01 small preset, 2'b00 parallel. The mode holds until the next reset.
- R2: In the large-preset mode, both `ofs_low` and `ofs_high` equal `PRESET_LARGE` (64). In the small-preset mode, both equal `PRESET_SMALL` (8). No further programming is needed.
- R3: In the preset and parallel modes, `wr_ready` is low during reset. It is low after the first clock edge with `rst_n` high, and it rises on the second such edge.
- R4: In parallel mode, the first accepted write (`wr_req` high while `wr_ready` is high) loads `ofs_high` from `wr_data[9:0]`, with bit 9 as the MSB. The second accepted write loads `ofs_low` the same way. `mem_wr_en` stays low during both.
- R5: Once programming is finished, or at once in the preset modes, `mem_wr_en` follows `wr_req` whenever `wr_ready` is high.
- R6: In serial mode, every clock edge with `sel_sen` low takes one bit from `sel_sd`. Edges with `sel_sen` high take nothing, so gaps are allowed. Bit 1 is the MSB of `ofs_high` and bit 20 is the LSB of `ofs_low`. Both offsets update on the edge that takes bit 20.
- R7: In serial mode, `wr_ready` stays low until 20 bits have been taken. It rises on the clock edge after the one that took bit 20. Any later serial bits are ignored.
- R8: A write strobe while `wr_ready` is low has no effect: `mem_wr_en` stays low and no parallel load happens.
- R9: Once `wr_ready` is high, it stays high until the next reset.
- R10: After programming ends, `ofs_low` and `ofs_high` do not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| sel_sen | input | 1 | Mode select bit 1 during reset; active-low serial enable afterwards |
| sel_sd | input | 1 | Mode select bit 0 during reset; serial data afterwards |
| wr_req | input | 1 | Port write strobe |
| wr_data | input | OFS_W | Low bits of the port write data |
| ofs_low | output | OFS_W | Low-water (almost-empty) offset |
| ofs_high | output | OFS_W | High-water (almost-full) offset |
| wr_ready | output | 1 | Writes are accepted |
| mem_wr_en | output | 1 | The current strobe may store a word in memory |

## Verification
The assertions check several rules on every cycle. No memory write happens without ready and a strobe, and none happens on a programming write. Ready stays low in serial mode until the shifter reports completion, and it never falls once raised. The offsets do not move after programming, and the preset values hold. Other behaviour can only be shown by the bench's scenarios against values it computes itself: the exact clock on which ready rises, the Y-then-X order of parallel loads, and the bit order of a gapped serial stream. The same applies to writes dropped before ready and serial bits dropped after the twentieth.

// File: rtl/ofsp_pkg.sv
package ofsp_pkg;

  typedef enum logic [1:0] {
    M_PARALLEL  = 2'b00,
    M_PRESET_SM = 2'b01,
    M_PRESET_LG = 2'b10,
    M_SERIAL    = 2'b11
  } load_mode_e;

  // Pin pair to mode: bit 1 is the enable pin, bit 0 the data pin.
  function automatic load_mode_e decode_mode(input logic s1, input logic s0);
    return load_mode_e'({s1, s0});
  endfunction

  // Preset value for a mode; zero where the mode loads later.
  function automatic int unsigned preset_for(input load_mode_e m,
                                             input int unsigned small_v,
                                             input int unsigned large_v);
    case (m)
      M_PRESET_SM: return small_v;
      M_PRESET_LG: return large_v;
      default:     return 0;
    endcase
  endfunction

  // A parallel-mode write is still a programming write.
  function automatic logic is_prog_write(input load_mode_e m, input logic [1:0] taken);
    return (m == M_PARALLEL) && (taken != 2'd2);
  endfunction

endpackage

// File: rtl/ofsp_mode_latch.sv
module ofsp_mode_latch
  import ofsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel1,
  input  logic       sel0,
  output load_mode_e mode
);
  // Follows the pins while reset is low; frozen on release.
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= decode_mode(sel1, sel0);
  end
endmodule

// File: rtl/ofsp_serial_shift.sv
module ofsp_serial_shift #(
  parameter int OFS_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sen_n,
  input  logic               sd,
  output logic               full,
  output logic               last_take,
  output logic [2*OFS_W-1:0] next_word
);
  localparam int NBITS = 2 * OFS_W;
  localparam int CW    = $clog2(NBITS + 1);

  logic [NBITS-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic             take;

  assign full      = (cnt == CW'(NBITS));
  assign take      = enable && !sen_n && !full;
  assign last_take = take && (cnt == CW'(NBITS - 1));
  assign next_word = {shreg[NBITS-2:0], sd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (take) begin
      shreg <= next_word;
      cnt   <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/ofsp_ready_gen.sv
module ofsp_ready_gen #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serial_mode,
  input  logic ser_full,
  output logic wr_ready
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt;
  logic          settled_edge;

  assign settled_edge = (cnt == CW'(SETTLE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      wr_ready <= 1'b0;
    end else begin
      if (cnt != CW'(SETTLE)) cnt <= cnt + CW'(1);
      if (serial_mode) wr_ready <= wr_ready | ser_full;
      else             wr_ready <= wr_ready | settled_edge;
    end
  end
endmodule

// File: rtl/fill_offset_loader.sv
module fill_offset_loader
  import ofsp_pkg::*;
#(
  parameter int OFS_W        = 10,
  parameter int PRESET_SMALL = 8,
  parameter int PRESET_LARGE = 64,
  parameter int SETTLE       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_sen,
  input  logic             sel_sd,
  input  logic             wr_req,
  input  logic [OFS_W-1:0] wr_data,
  output logic [OFS_W-1:0] ofs_low,
  output logic [OFS_W-1:0] ofs_high,
  output logic             wr_ready,
  output logic             mem_wr_en
);
  load_mode_e         mode;
  logic               ser_full;
  logic               ser_last;
  logic [2*OFS_W-1:0] ser_word;
  logic [1:0]         par_taken;
  logic               accepted;
  logic               par_load_high;
  logic               par_load_low;
  logic               prog_write;
  logic [OFS_W-1:0]   reset_value;

  ofsp_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .sel1(sel_sen), .sel0(sel_sd), .mode(mode)
  );

  ofsp_serial_shift #(.OFS_W(OFS_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .enable(mode == M_SERIAL),
    .sen_n(sel_sen), .sd(sel_sd),
    .full(ser_full), .last_take(ser_last), .next_word(ser_word)
  );

  ofsp_ready_gen #(.SETTLE(SETTLE)) u_rdy (
    .clk(clk), .rst_n(rst_n), .serial_mode(mode == M_SERIAL),
    .ser_full(ser_full), .wr_ready(wr_ready)
  );

  assign accepted      = wr_req && wr_ready;
  assign prog_write    = is_prog_write(mode, par_taken);
  assign par_load_high = accepted && prog_write && (par_taken == 2'd0);
  assign par_load_low  = accepted && prog_write && (par_taken == 2'd1);
  assign mem_wr_en     = accepted && !prog_write;
  assign reset_value   = OFS_W'(preset_for(decode_mode(sel_sen, sel_sd),
                                           PRESET_SMALL, PRESET_LARGE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_low   <= reset_value;
      ofs_high  <= reset_value;
      par_taken <= 2'd0;
    end else begin
      if (par_load_high) begin
        ofs_high  <= wr_data;
        par_taken <= 2'd1;
      end
      if (par_load_low) begin
        ofs_low   <= wr_data;
        par_taken <= 2'd2;
      end
      if (ser_last) begin
        ofs_high <= ser_word[2*OFS_W-1:OFS_W];
        ofs_low  <= ser_word[OFS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ofsp_checker.sv
module ofsp_checker
  import ofsp_pkg::*;
#(
  parameter int OFS_W        = 10,
  parameter int PRESET_SMALL = 8,
  parameter int PRESET_LARGE = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_req,
  input logic             wr_ready,
  input logic             mem_wr_en,
  input logic [OFS_W-1:0] ofs_low,
  input logic [OFS_W-1:0] ofs_high,
  input load_mode_e       mode,
  input logic             par_load_high,
  input logic             par_load_low,
  input logic             ser_full
);
  a_r8_mem_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (wr_ready && wr_req));

  a_r4_no_mem_on_program: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load_high || par_load_low) |-> !mem_wr_en);

  a_r7_serial_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SERIAL && !ser_full) |-> !wr_ready);

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);

  a_r10_offsets_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !par_load_high && !par_load_low) |=> ($stable(ofs_low) && $stable(ofs_high)));

  a_r2_preset_value: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRESET_LG) |-> (ofs_low == OFS_W'(PRESET_LARGE) && ofs_high == OFS_W'(PRESET_LARGE)));

  a_r2_preset_small: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRESET_SM) |-> (ofs_low == OFS_W'(PRESET_SMALL) && ofs_high == OFS_W'(PRESET_SMALL)));
endmodule

bind fill_offset_loader ofsp_checker #(
  .OFS_W(OFS_W), .PRESET_SMALL(PRESET_SMALL), .PRESET_LARGE(PRESET_LARGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ready(wr_ready),
  .mem_wr_en(mem_wr_en), .ofs_low(ofs_low), .ofs_high(ofs_high),
  .mode(mode), .par_load_high(par_load_high), .par_load_low(par_load_low),
  .ser_full(ser_full)
);

// File: tb/sim_fill_offset_loader.sv
`timescale 1ns/1ps
module sim_fill_offset_loader;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_sen = 1'b0;
  logic         sel_sd = 1'b0;
  logic         wr_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] ofs_low, ofs_high;
  logic         wr_ready, mem_wr_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fill_offset_loader u0 (
    .clk(clk), .rst_n(rst_n), .sel_sen(sel_sen), .sel_sd(sel_sd),
    .wr_req(wr_req), .wr_data(wr_data), .ofs_low(ofs_low), .ofs_high(ofs_high),
    .wr_ready(wr_ready), .mem_wr_en(mem_wr_en)
  );

  function automatic int exp_preset(input bit s1, input bit s0);
    if (s1 && !s0) return 64;
    if (!s1 && s0) return 8;
    return 0;
  endfunction

  // Bit k (0-based, in send order) of the stream for high then low.
  function automatic bit stream_bit(input int hi, input int lo, input int k);
    if (k < W) return 1'(hi >> (W - 1 - k));
    return 1'(lo >> (2 * W - 1 - k));
  endfunction

  function automatic int rand_ofs();
    return 1 + int'($urandom % 1020);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit s1, input bit s0);
    @(negedge clk);
    rst_n = 1'b0; sel_sen = s1; sel_sd = s0; wr_req = 1'b1;
    repeat (4) @(negedge clk);
    check(wr_ready == 1'b0, "R3 ready low in reset", wr_ready, 0);
    check(mem_wr_en == 1'b0, "R8 no mem write in reset", mem_wr_en, 0);
    rst_n = 1'b1; wr_req = 1'b0;
    sel_sen = 1'b1;
  endtask

  task automatic run_preset(input bit s1, input bit s0);
    int pv;
    pv = exp_preset(s1, s0);
    do_reset(s1, s0);
    wr_req = 1'b1;
    #1 check(mem_wr_en == 1'b0, "R8 strobe ignored before ready", mem_wr_en, 0);
    @(negedge clk);
    check(wr_ready == 1'b0, "R3 ready low after first edge", wr_ready, 0);
    @(negedge clk);
    check(wr_ready == 1'b1, "R3 ready high after second edge", wr_ready, 1);
    check(ofs_low == W'(pv), "R2 preset low offset", ofs_low, pv);
    check(ofs_high == W'(pv), "R2 preset high offset", ofs_high, pv);
    check(mem_wr_en == 1'b1, "R5 preset write reaches memory", mem_wr_en, 1);
    wr_req = 1'b0;
    #1 check(mem_wr_en == 1'b0, "R5 no strobe no write", mem_wr_en, 0);
  endtask

  task automatic run_parallel();
    int hi, lo;
    hi = rand_ofs(); lo = rand_ofs();
    do_reset(1'b0, 1'b0);
    wr_req = 1'b1; wr_data = W'($urandom);
    @(negedge clk);
    check(wr_ready == 1'b0, "R3 parallel ready low after first edge", wr_ready, 0);
    check(mem_wr_en == 1'b0, "R8 ignored write before ready", mem_wr_en, 0);
    @(negedge clk);
    check(wr_ready == 1'b1, "R3 parallel ready after second edge", wr_ready, 1);
    wr_data = W'(hi);
    #1 check(mem_wr_en == 1'b0, "R4 first program write not stored", mem_wr_en, 0);
    @(negedge clk);
    wr_req = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
    wr_req = 1'b1; wr_data = W'(lo);
    #1 check(mem_wr_en == 1'b0, "R4 second program write not stored", mem_wr_en, 0);
    @(negedge clk);
    wr_data = W'($urandom);
    check(ofs_high == W'(hi), "R4 first write loads high offset", ofs_high, hi);
    check(ofs_low == W'(lo), "R4 second write loads low offset", ofs_low, lo);
    #1 check(mem_wr_en == 1'b1, "R5 third write stored", mem_wr_en, 1);
    @(negedge clk);
    check(ofs_high == W'(hi) && ofs_low == W'(lo), "R10 offsets hold after data write", ofs_low, lo);
    wr_req = 1'b0;
  endtask

  task automatic run_serial(input bit gapped);
    int hi, lo;
    hi = rand_ofs(); lo = rand_ofs();
    do_reset(1'b1, 1'b1);
    for (int k = 0; k < 2 * W; k++) begin
      if (gapped) begin
        sel_sen = 1'b1; sel_sd = 1'($urandom);
        repeat ($urandom % 3) @(negedge clk);
      end
      sel_sen = 1'b0; sel_sd = stream_bit(hi, lo, k);
      wr_req = 1'($urandom);
      #1 check(mem_wr_en == 1'b0, "R8 no mem write while serial pending", mem_wr_en, 0);
      @(negedge clk);
      if (k < 2 * W - 1)
        check(wr_ready == 1'b0, "R7 ready low before stream ends", wr_ready, 0);
    end
    check(wr_ready == 1'b0, "R7 ready still low on last-bit edge", wr_ready, 0);
    check(ofs_high == W'(hi), "R6 serial high offset", ofs_high, hi);
    check(ofs_low == W'(lo), "R6 serial low offset", ofs_low, lo);
    sel_sen = 1'b0; sel_sd = ~sel_sd; wr_req = 1'b0;
    @(negedge clk);
    check(wr_ready == 1'b1, "R7 ready rises edge after last bit", wr_ready, 1);
    repeat (3) begin
      sel_sd = 1'($urandom);
      @(negedge clk);
    end
    check(ofs_high == W'(hi) && ofs_low == W'(lo), "R7 extra serial bits ignored", ofs_high, hi);
    sel_sen = 1'b1; wr_req = 1'b1;
    #1 check(mem_wr_en == 1'b1, "R5 serial-mode write stored", mem_wr_en, 1);
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_preset(1'b1, 1'b0);   // R1 large preset
    run_preset(1'b0, 1'b1);   // R1 small preset
    run_parallel();           // R1 parallel
    run_serial(1'b0);         // R1 serial, back to back
    run_serial(1'b1);         // R6 gapped serial
    for (int r = 0; r < 8; r++) begin
      case ($urandom % 4)
        0: run_preset(1'b1, 1'b0);
        1: run_preset(1'b0, 1'b1);
        2: run_parallel();
        default: run_serial(1'($urandom));
      endcase
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule